// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block picks the smaller or larger of two IEEE 754 binary floating-point operands. The format width is set by a parameter and may be half (16), single (32) or double (64) precision. One control input chooses the operation: minimum or maximum. A tag word travels with the operands and comes out unchanged. That lets a caller match each result to the request that produced it when several requesters share the unit.

NaN handling follows the "number wins" convention. If one operand is a NaN and the other is a number, the number is returned bit for bit. If both operands are NaN, the result is a single canonical quiet NaN. For two numbers, the sign bits are examined first. When the signs are equal, the remaining exponent and mantissa bits are compared as an unsigned integer, and that comparison is inverted when both operands are negative. This ordering needs no subtractor.

There is no storage: the result is combinational from the operands. A valid/ready pair wraps the data path. `out_valid` follows `in_valid` in the same cycle and `in_ready` mirrors `out_ready`. Back-pressure therefore passes straight through: an operand pair counts as consumed only in a cycle where both `in_valid` and `out_ready` are high. The producer must hold the operands stable while `in_ready` is low.

Top module: `fp_minmax`

## Requirements
- R1: Whenever `in_valid` is high, `out_res` is bit-identical to `in_a`, to `in_b`, or to the canonical quiet NaN.
- R2: When both operands are NaN, `out_res` is the canonical quiet NaN, for both operations. Its sign bit is clear, its exponent bits are all ones, its mantissa MSB is set and all other mantissa bits are zero. That is 0x7E00 at 16 bits, 0x7FC00000 at 32 bits and 0x7FF8000000000000 at 64 bits.
- R3: When exactly one operand is NaN, `out_res` equals the other operand unchanged, for both minimum and maximum.
- R4: When the two sign bits (MSB) differ, maximum returns the operand with the clear sign bit and minimum returns the other one. So maximum of +0 and -0 gives +0, and minimum gives -0, in either operand order.
- R5: When both sign bits are clear, the operand whose low FP_W-1 bits form the larger unsigned integer is the larger value. This holds for subnormals too.
- R6: When both sign bits are set, the operand with the larger unsigned low FP_W-1 bits is the smaller value.
- R7: An operand is NaN exactly when its exponent field is all ones and its mantissa field is non-zero. An all-ones exponent with a zero mantissa is an infinity and is ordered as a number. The exponent field is 5, 8 or 11 bits wide for widths 16, 32 and 64, and the mantissa fills the bits below it.
- R8: `in_op_max` = 1 selects maximum and `in_op_max` = 0 selects minimum.
- R9: `out_tag` equals `in_tag` in the same cycle.
- R10: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` in the same cycle, including during reset.
- R11: The parameter FP_W selects the 16-, 32- or 64-bit format, and every rule above holds at each of these widths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_valid | input | 1 | Operand pair and operation are present |
| in_ready | output | 1 | Downstream can take a result (mirrors out_ready) |
| in_a | input | FP_W | First floating-point operand |
| in_b | input | FP_W | Second floating-point operand |
| in_op_max | input | 1 | 1 = maximum, 0 = minimum |
| in_tag | input | TAG_W | Requester tag carried alongside the operands |
| out_valid | output | 1 | Result is present (follows in_valid) |
| out_ready | input | 1 | Downstream accepts the result |
| out_res | output | FP_W | Selected operand or canonical quiet NaN |
| out_tag | output | TAG_W | Tag returned unchanged |

## Verification
The bench instantiates the unit three times, with FP_W set to 32, 16 and 64, and TAG_W kept at 4. The single-precision instance carries most scenarios: signed zeros, infinities, subnormals, signalling and negative NaNs, and tag and handshake pass-through. The half-precision and double-precision instances exercise the other exponent field widths. They show that the canonical NaN changes shape with the format and that the magnitude compare spans the full low FP_W-1 bits at both ends of the width range.

// File: rtl/fpmm_pkg.sv
`timescale 1ns/1ps
package fpmm_pkg;

  // Exponent field width for the supported binary formats.
  function automatic int exp_bits(input int w);
    return (w == 16) ? 5 : (w == 32) ? 8 : 11;
  endfunction

  // Mantissa field width: everything below sign and exponent.
  function automatic int man_bits(input int w);
    return w - 1 - exp_bits(w);
  endfunction

  // Per-operand classification used by the selector.
  typedef struct packed {
    logic sign;
    logic is_nan;
  } fp_class_t;

  // What the output multiplexer drives.
  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_QNAN = 2'd2
  } pick_e;

endpackage

// File: rtl/fpmm_classify.sv
`timescale 1ns/1ps
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] op,
  output fp_class_t    cls
);

  localparam int EW = exp_bits(W);
  localparam int MW = man_bits(W);

  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;

  always_comb begin
    exp_f      = op[W-2 -: EW];
    man_f      = op[MW-1:0];
    cls.sign   = op[W-1];
    // exponent saturated and a non-empty fraction
    cls.is_nan = (&exp_f) && (|man_f);
  end

endmodule

// File: rtl/fpmm_order.sv
`timescale 1ns/1ps
module fpmm_order #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         b_wins_max,
  output logic         same
);

  localparam int MAGW = W - 1;

  logic [MAGW-1:0] mag_a;
  logic [MAGW-1:0] mag_b;
  logic            mag_lt;

  always_comb begin
    mag_a  = a[MAGW-1:0];
    mag_b  = b[MAGW-1:0];
    mag_lt = mag_a < mag_b;
    if (a[W-1] != b[W-1]) begin
      // a negative and b positive: b is larger
      b_wins_max = a[W-1];
    end else begin
      // same sign: larger magnitude wins unless both negative
      b_wins_max = mag_lt ^ a[W-1];
    end
    same = (a == b);
  end

endmodule

// File: rtl/fpmm_select.sv
`timescale 1ns/1ps
module fpmm_select
  import fpmm_pkg::*;
(
  input  fp_class_t cls_a,
  input  fp_class_t cls_b,
  input  logic      b_wins_max,
  input  logic      same,
  input  logic      want_max,
  output pick_e     pick
);

  always_comb begin
    if (cls_a.is_nan && cls_b.is_nan) begin
      pick = PICK_QNAN;
    end else if (cls_a.is_nan) begin
      pick = PICK_B;
    end else if (cls_b.is_nan) begin
      pick = PICK_A;
    end else if (same) begin
      pick = PICK_A;
    end else if (want_max) begin
      pick = b_wins_max ? PICK_B : PICK_A;
    end else begin
      pick = b_wins_max ? PICK_A : PICK_B;
    end
  end

endmodule

// File: rtl/fp_minmax.sv
`timescale 1ns/1ps
module fp_minmax
  import fpmm_pkg::*;
#(
  parameter int FP_W  = 32,
  parameter int TAG_W = 4
) (
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [FP_W-1:0]  in_a,
  input  logic [FP_W-1:0]  in_b,
  input  logic             in_op_max,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FP_W-1:0]  out_res,
  output logic [TAG_W-1:0] out_tag
);

  localparam int EW = exp_bits(FP_W);
  localparam int MW = man_bits(FP_W);
  localparam logic [FP_W-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam int NOPS = 2;

  logic [NOPS-1:0][FP_W-1:0] ops;
  fp_class_t [NOPS-1:0]      cls;
  logic                      b_wins_max;
  logic                      same;
  pick_e                     pick;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_cls
    fpmm_classify #(.W(FP_W)) u_cls (
      .op  (ops[gi]),
      .cls (cls[gi])
    );
  end

  fpmm_order #(.W(FP_W)) u_order (
    .a          (in_a),
    .b          (in_b),
    .b_wins_max (b_wins_max),
    .same       (same)
  );

  fpmm_select u_sel (
    .cls_a      (cls[0]),
    .cls_b      (cls[1]),
    .b_wins_max (b_wins_max),
    .same       (same),
    .want_max   (in_op_max),
    .pick       (pick)
  );

  always_comb begin
    case (pick)
      PICK_A:  out_res = in_a;
      PICK_B:  out_res = in_b;
      default: out_res = QNAN;
    endcase
  end

  assign out_tag   = in_tag;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

endmodule

// File: rtl/fpmm_chk.sv
`timescale 1ns/1ps
module fpmm_chk
  import fpmm_pkg::*;
#(
  parameter int FP_W  = 32,
  parameter int TAG_W = 4
) (
  input logic             in_valid,
  input logic             in_ready,
  input logic [FP_W-1:0]  in_a,
  input logic [FP_W-1:0]  in_b,
  input logic             in_op_max,
  input logic [TAG_W-1:0] in_tag,
  input logic             out_valid,
  input logic             out_ready,
  input logic [FP_W-1:0]  out_res,
  input logic [TAG_W-1:0] out_tag
);

  localparam int EW = exp_bits(FP_W);
  localparam int MW = man_bits(FP_W);
  localparam logic [FP_W-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  logic a_nan;
  logic b_nan;
  logic want_pos;

  always_comb begin
    a_nan    = (&in_a[FP_W-2 -: EW]) && (|in_a[MW-1:0]);
    b_nan    = (&in_b[FP_W-2 -: EW]) && (|in_b[MW-1:0]);
    want_pos = in_op_max;
    if (in_valid) begin
      // R1
      result_member_chk: assert (out_res == in_a || out_res == in_b || out_res == CANON)
        else $error("result is neither operand nor canonical NaN");
      // R2
      both_nan_chk: assert (!(a_nan && b_nan) || out_res == CANON)
        else $error("two NaNs must give canonical NaN");
      // R3
      one_nan_chk: assert (!(a_nan ^ b_nan) || out_res == (a_nan ? in_b : in_a))
        else $error("single NaN must yield the other operand");
      // R4
      sign_order_chk: assert (a_nan || b_nan || in_a[FP_W-1] == in_b[FP_W-1]
                              || out_res[FP_W-1] == !want_pos)
        else $error("mixed signs ordered wrongly");
      // R9
      tag_pass_chk: assert (out_tag == in_tag)
        else $error("tag altered");
    end
    // R10
    handshake_chk: assert (out_valid == in_valid && in_ready == out_ready)
      else $error("handshake not passed through");
  end

endmodule

bind fp_minmax fpmm_chk #(.FP_W(FP_W), .TAG_W(TAG_W)) u_fpmm_chk (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_op_max (in_op_max),
  .in_tag    (in_tag),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_res   (out_res),
  .out_tag   (out_tag)
);

// File: tb/test_fp_minmax.sv
`timescale 1ns/1ps
module test_fp_minmax;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // single precision instance
  logic        s_valid = 0, s_ready, s_max = 0, s_oval, s_ordy = 1;
  logic [31:0] s_a = 0, s_b = 0, s_res;
  logic [3:0]  s_tag = 0, s_otag;
  // half precision instance
  logic        h_valid = 0, h_ready, h_max = 0, h_oval, h_ordy = 1;
  logic [15:0] h_a = 0, h_b = 0, h_res;
  logic [3:0]  h_tag = 0, h_otag;
  // double precision instance
  logic        d_valid = 0, d_ready, d_max = 0, d_oval, d_ordy = 1;
  logic [63:0] d_a = 0, d_b = 0, d_res;
  logic [3:0]  d_tag = 0, d_otag;

  fp_minmax #(.FP_W(32), .TAG_W(4)) i_fp_minmax (
    .in_valid(s_valid), .in_ready(s_ready), .in_a(s_a), .in_b(s_b),
    .in_op_max(s_max), .in_tag(s_tag), .out_valid(s_oval),
    .out_ready(s_ordy), .out_res(s_res), .out_tag(s_otag));

  fp_minmax #(.FP_W(16), .TAG_W(4)) i_fp_minmax_h16 (
    .in_valid(h_valid), .in_ready(h_ready), .in_a(h_a), .in_b(h_b),
    .in_op_max(h_max), .in_tag(h_tag), .out_valid(h_oval),
    .out_ready(h_ordy), .out_res(h_res), .out_tag(h_otag));

  fp_minmax #(.FP_W(64), .TAG_W(4)) i_fp_minmax_d64 (
    .in_valid(d_valid), .in_ready(d_ready), .in_a(d_a), .in_b(d_b),
    .in_op_max(d_max), .in_tag(d_tag), .out_valid(d_oval),
    .out_ready(d_ordy), .out_res(d_res), .out_tag(d_otag));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request on the instance of width w and check the result and tag.
  task automatic apply(input int w, input logic [63:0] a, input logic [63:0] b,
                       input logic mx, input logic [3:0] tag,
                       input logic [63:0] exp, input string req);
    logic [63:0] res;
    logic [3:0]  otag;
    @(posedge clk); #1;
    case (w)
      16: begin h_a = a[15:0]; h_b = b[15:0]; h_max = mx; h_tag = tag; h_valid = 1; end
      64: begin d_a = a;       d_b = b;       d_max = mx; d_tag = tag; d_valid = 1; end
      default: begin s_a = a[31:0]; s_b = b[31:0]; s_max = mx; s_tag = tag; s_valid = 1; end
    endcase
    @(negedge clk);
    case (w)
      16: begin res = {48'd0, h_res}; otag = h_otag; end
      64: begin res = d_res;          otag = d_otag; end
      default: begin res = {32'd0, s_res}; otag = s_otag; end
    endcase
    check(req, res, exp);
    check("R9 tag", {60'd0, otag}, {60'd0, tag});
  endtask

  task automatic t_reset;
    // R10: valid low, out_ready toggled during reset
    @(negedge clk);
    check("R10 reset out_valid", {63'd0, s_oval}, 64'd0);
    s_ordy = 0;
    #1;
    check("R10 reset in_ready", {63'd0, s_ready}, 64'd0);
    s_ordy = 1;
    #1;
    check("R10 reset in_ready high", {63'd0, s_ready}, 64'd1);
  endtask

  task automatic t_positive;
    apply(32, 64'h3F800000, 64'h40000000, 1, 4'h1, 64'h40000000, "R5 max(1,2)");
    apply(32, 64'h3F800000, 64'h40000000, 0, 4'h2, 64'h3F800000, "R5 min(1,2)");
    apply(32, 64'h00000001, 64'h00000000, 1, 4'h3, 64'h00000001, "R5 max subnormal");
    apply(32, 64'h00000001, 64'h00000000, 0, 4'h4, 64'h00000000, "R5 min subnormal");
  endtask

  task automatic t_negative;
    apply(32, 64'hBF800000, 64'hC0000000, 1, 4'h5, 64'hBF800000, "R6 max(-1,-2)");
    apply(32, 64'hBF800000, 64'hC0000000, 0, 4'h6, 64'hC0000000, "R6 min(-1,-2)");
    apply(32, 64'hC0000000, 64'hBF800000, 1, 4'h7, 64'hBF800000, "R6 max(-2,-1)");
  endtask

  task automatic t_sign;
    apply(32, 64'hBF800000, 64'h40000000, 1, 4'h8, 64'h40000000, "R4 max(-1,2)");
    apply(32, 64'hBF800000, 64'h40000000, 0, 4'h9, 64'hBF800000, "R4 min(-1,2)");
    apply(32, 64'h00000000, 64'h80000000, 1, 4'hA, 64'h00000000, "R4 max(+0,-0)");
    apply(32, 64'h00000000, 64'h80000000, 0, 4'hB, 64'h80000000, "R4 min(+0,-0)");
    apply(32, 64'h80000000, 64'h00000000, 1, 4'hC, 64'h00000000, "R4 max(-0,+0)");
    apply(32, 64'h80000000, 64'h00000000, 0, 4'hD, 64'h80000000, "R4 min(-0,+0)");
  endtask

  task automatic t_nan_one;
    apply(32, 64'h7FC00000, 64'h3F800000, 1, 4'h1, 64'h3F800000, "R3 max(nan,1)");
    apply(32, 64'h3F800000, 64'hFFC00001, 0, 4'h2, 64'h3F800000, "R3 min(1,-nan)");
    apply(32, 64'hC0000000, 64'h7F800001, 1, 4'h3, 64'hC0000000, "R3 max(-2,snan)");
  endtask

  task automatic t_nan_both;
    apply(32, 64'h7F800001, 64'hFFC12345, 1, 4'h4, 64'h7FC00000, "R2 R1 max(nan,nan)");
    apply(32, 64'hFFFFFFFF, 64'h7FC00000, 0, 4'h5, 64'h7FC00000, "R2 min(nan,nan)");
  endtask

  task automatic t_special;
    apply(32, 64'h7F800000, 64'h40000000, 1, 4'h6, 64'h7F800000, "R7 max(inf,2)");
    apply(32, 64'hFF800000, 64'h7F800001, 0, 4'h7, 64'hFF800000, "R7 min(-inf,snan)");
    apply(32, 64'h7F800000, 64'hFF800000, 0, 4'h8, 64'hFF800000, "R7 min(inf,-inf)");
  endtask

  task automatic t_op;
    apply(32, 64'h40400000, 64'h40000000, 1, 4'h9, 64'h40400000, "R8 op=1 maximum");
    apply(32, 64'h40400000, 64'h40000000, 0, 4'hA, 64'h40000000, "R8 op=0 minimum");
  endtask

  task automatic t_widths;
    apply(16, 64'h3C00, 64'h4000, 1, 4'h1, 64'h4000, "R11 half max(1,2)");
    apply(16, 64'hBC00, 64'hC000, 0, 4'h2, 64'hC000, "R11 half min(-1,-2)");
    apply(16, 64'h7C01, 64'hFE00, 1, 4'h3, 64'h7E00, "R2 R11 half nan,nan");
    apply(16, 64'h7C00, 64'h7C01, 0, 4'h4, 64'h7C00, "R7 R11 half inf vs nan");
    apply(64, 64'hBFF0000000000000, 64'h3FF0000000000000, 0, 4'h5,
          64'hBFF0000000000000, "R11 double min(-1,1)");
    apply(64, 64'h0000000000000001, 64'h0000000000000002, 1, 4'h6,
          64'h0000000000000002, "R5 R11 double max subnormal");
    apply(64, 64'h7FF0000000000001, 64'hFFF8000000000000, 0, 4'h7,
          64'h7FF8000000000000, "R2 R11 double nan,nan");
  endtask

  task automatic t_handshake;
    @(posedge clk); #1;
    s_valid = 0; s_ordy = 0;
    @(negedge clk);
    check("R10 out_valid low", {63'd0, s_oval}, 64'd0);
    check("R10 in_ready low", {63'd0, s_ready}, 64'd0);
    @(posedge clk); #1;
    s_valid = 1;
    @(negedge clk);
    check("R10 out_valid high under backpressure", {63'd0, s_oval}, 64'd1);
    check("R10 in_ready still low", {63'd0, s_ready}, 64'd0);
    @(posedge clk); #1;
    s_ordy = 1;
    @(negedge clk);
    check("R10 in_ready released", {63'd0, s_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_positive();
    t_negative();
    t_sign();
    t_nan_one();
    t_nan_both();
    t_special();
    t_op();
    t_widths();
    t_handshake();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule